// File: doc/BRIEF.md
# Triggered Binary Hit Pipeline Readout

This block sits behind a bank of 254 binary comparators in a strip-detector front end. On every bunch-crossing clock it writes the full comparator word into a 256-location circular memory, so the memory always holds the most recent 256 crossings. The level-1 trigger decision arrives a fixed number of crossings after the interaction. When a trigger is sampled, the block reads the location that lies `latency` crossings behind the write pointer. It queues that word in a 32-slot event buffer, together with its pipeline address.

A serial transmitter drains the event buffer one event at a time. Each event goes out as a fixed 266-bit unsparsified frame: every channel bit is sent whatever the occupancy. A fast-reset command throws away all queued events and any frame in progress. The circular pipeline keeps running through it. Latency is a static input that changes only while no trigger is pending.

Top module: `hit_pipe_readout`

## Requirements
- R1: After reset the pipeline write address starts at 0 and advances by one (mod 256) on every clock. The hit word present at that edge is stored at that address.
- R2: A trigger sampled at an edge when the write address is W queues the word stored at address (W - latency) mod 256, together with that 8-bit address.
- R3: Up to 32 events can wait in the buffer. A trigger sampled while 32 events are waiting is dropped and sets a sticky overflow flag. Only reset or fast reset clears the flag.
- R4: A frame is 266 bits sent MSB first, in this order: two start bits of 1, then the overflow flag as it stands when the frame is loaded, then the zero-latency flag of the event, then the 8-bit pipeline address (MSB first), then channel 1 through channel 254. Channel k is `hits[k-1]`.
- R5: Suppose the trigger is sampled at edge E while the transmitter is idle and the buffer is empty. The first start bit is then driven after edge E+1.
- R6: Events leave in trigger order. When further events are waiting, exactly one low bit period separates the last bit of one frame from the first start bit of the next.
- R7: `data_out` is low during reset and whenever no frame is being sent.
- R8: Fast reset empties the buffer, aborts the current frame so that `data_out` is low after that edge, and clears the overflow flag. The write address keeps advancing. A trigger sampled together with fast reset is ignored.
- R9: When the latency is 0, the event's zero-latency flag is 1. The queued word is then the one written 256 clocks earlier, which is the content of the location being overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hits | input | 254 | Comparator word, bit k-1 is channel k |
| trig | input | 1 | Level-1 trigger command, one cycle per trigger |
| fast_rst | input | 1 | Fast reset command |
| latency | input | 8 | Trigger latency in clocks |
| data_out | output | 1 | Serial frame output |

## Verification
The assertions take for granted that `trig` and `fast_rst` are synchronous single-cycle commands and that `latency` is steady whenever a trigger is sampled. The bench drives every input on the falling clock edge and changes `latency` only while the buffer is empty. It holds commands for exactly one cycle, except in the back-to-back burst, where each cycle carries a new trigger. Before the first trigger it waits longer than one full pipeline turn, so that every read location holds a word the bench knows.

// File: rtl/hit_pipe_readout.sv
module hit_pipe_readout #(
  parameter int NCH   = 254,
  parameter int DEPTH = 256,
  parameter int BUFD  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCH-1:0]               hits,
  input  logic                         trig,
  input  logic                         fast_rst,
  input  logic [$clog2(DEPTH)-1:0]     latency,
  output logic                         data_out
);
  localparam int AW   = $clog2(DEPTH);
  localparam int BW   = $clog2(BUFD);
  localparam int EW   = AW + 1 + NCH;
  localparam int FLEN = 4 + AW + NCH;
  localparam int CW   = $clog2(FLEN);

  logic [NCH-1:0]  mem [DEPTH];
  logic [EW-1:0]   evq [BUFD];
  logic [AW-1:0]   wr_ptr;
  logic [BW-1:0]   qh, qt;
  logic [BW:0]     qcnt;
  logic            busy, ovf;
  logic [FLEN-1:0] sreg, frame_w;
  logic [CW-1:0]   left;
  logic [EW-1:0]   head;

  wire [AW-1:0] rd_addr = wr_ptr - latency;
  wire full = (qcnt == (BW+1)'(BUFD));
  wire push = trig && !fast_rst && !full;
  wire pop  = !busy && (qcnt != '0) && !fast_rst;

  assign data_out = busy & sreg[FLEN-1];

  always_ff @(posedge clk) begin
    mem[wr_ptr] <= hits;
    if (push) evq[qt] <= {rd_addr, latency == '0, mem[rd_addr]};
  end

  always_comb begin
    head = evq[qh];
    frame_w[FLEN-1:FLEN-4] = {2'b11, ovf, head[NCH]};
    frame_w[NCH+AW-1:NCH]  = head[EW-1:NCH+1];
    for (int i = 0; i < NCH; i++) frame_w[NCH-1-i] = head[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      qh <= '0; qt <= '0; qcnt <= '0;
      busy <= 1'b0; ovf <= 1'b0;
      sreg <= '0; left <= '0;
    end else begin
      wr_ptr <= wr_ptr + 1'b1;
      if (fast_rst) begin
        qh <= '0; qt <= '0; qcnt <= '0;
        busy <= 1'b0; ovf <= 1'b0; left <= '0;
      end else begin
        if (trig && full) ovf <= 1'b1;
        if (push) qt <= qt + 1'b1;
        if (pop)  qh <= qh + 1'b1;
        qcnt <= qcnt + (BW+1)'(push) - (BW+1)'(pop);
        if (pop) begin
          sreg <= frame_w;
          busy <= 1'b1;
          left <= CW'(FLEN-1);
        end else if (busy) begin
          if (left == '0) busy <= 1'b0;
          else begin
            sreg <= sreg << 1;
            left <= left - 1'b1;
          end
        end
      end
    end
  end
endmodule

module hit_pipe_readout_chk #(
  parameter int AW   = 8,
  parameter int BUFD = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         trig,
  input logic                         fast_rst,
  input logic                         busy,
  input logic                         ovf,
  input logic                         data_out,
  input logic [$clog2(BUFD):0]        qcnt,
  input logic [AW-1:0]                wr_ptr
);
  localparam int QW = $clog2(BUFD) + 1;

  p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));
  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= QW'(BUFD));
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !fast_rst && qcnt == QW'(BUFD) |=> ovf);
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !fast_rst |=> ovf);
  p_start_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> data_out);
  p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && qcnt != '0 && !fast_rst |=> busy);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fast_rst |=> qcnt == '0 && !data_out && !ovf);
endmodule

bind hit_pipe_readout hit_pipe_readout_chk #(.AW(AW), .BUFD(BUFD)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .fast_rst(fast_rst),
  .busy(busy), .ovf(ovf), .data_out(data_out), .qcnt(qcnt), .wr_ptr(wr_ptr)
);

// File: tb/sim_hit_pipe_readout.sv
module sim_hit_pipe_readout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [253:0] hits = '0;
  logic trig = 1'b0, fast_rst = 1'b0;
  logic [7:0] latency = 8'd10;
  logic data_out;
  int ecnt = 0;
  int n_run = 0, n_fail = 0;
  int tq [64];

  always #4 clk = ~clk;

  hit_pipe_readout u0 (.clk(clk), .rst_n(rst_n), .hits(hits), .trig(trig),
    .fast_rst(fast_rst), .latency(latency), .data_out(data_out));

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;
  always @(negedge clk) hits <= pat(ecnt);

  function automatic logic [253:0] pat(int n);
    logic [253:0] p;
    for (int i = 0; i < 254; i++) p[i] = (((n * 13 + i * 7) % 11) < 3) ^ (i == (n % 254));
    return p;
  endfunction

  function automatic logic [265:0] mkframe(bit ov, bit lz, int addr, logic [253:0] d);
    logic [265:0] f;
    f[265:258] = {2'b11, ov, lz, 4'b0};
    f[261:254] = addr[7:0];
    for (int i = 0; i < 254; i++) f[253 - i] = d[i];
    return f;
  endfunction

  task automatic chk(bit ok, string req, string act, string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic get_frame(output logic [265:0] f, output int waited, input int tmo);
    waited = 0;
    f = '0;
    @(negedge clk);
    while (!data_out && waited < tmo) begin
      waited++;
      @(negedge clk);
    end
    if (waited >= tmo) return;
    f[265] = 1'b1;
    for (int b = 264; b >= 0; b--) begin
      @(negedge clk);
      f[b] = data_out;
    end
  endtask

  task automatic chk_frame(logic [265:0] f, logic [265:0] e, string req);
    chk(f === e, req, $sformatf("%h", f), $sformatf("%h", e));
  endtask

  task automatic pulse_trig(output int t);
    @(negedge clk);
    trig = 1'b1;
    t = ecnt;
    fork begin @(negedge clk); trig = 1'b0; end join_none
  endtask

  task automatic t_reset();
    chk(data_out === 1'b0, "R7 reset", $sformatf("%b", data_out), "0");
  endtask

  task automatic t_single(int lat);
    logic [265:0] f; int w, t;
    @(negedge clk); latency = lat[7:0];
    pulse_trig(t);
    get_frame(f, w, 1000);
    chk(w == 1, "R5 first start bit timing", $sformatf("%0d", w), "1");
    chk_frame(f, mkframe(0, 0, t - lat, pat(t - lat)), "R1 R2 R4 single frame");
    get_frame(f, w, 300);
    chk(w == 300, "R7 idle after frame", $sformatf("%0d", w), "300");
  endtask

  task automatic t_burst();
    logic [265:0] f; int w;
    @(negedge clk); latency = 8'd37;
    fork
      begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk); trig = 1'b1; tq[k] = ecnt;
        end
        @(negedge clk); trig = 1'b0;
      end
      begin
        for (int k = 0; k < 3; k++) begin
          get_frame(f, w, 1000);
          if (k > 0) chk(w == 1, "R6 gap between frames", $sformatf("%0d", w), "1");
          chk_frame(f, mkframe(0, 0, tq[k] - 37, pat(tq[k] - 37)), "R2 R6 burst order");
        end
      end
    join
  endtask

  task automatic t_overflow();
    logic [265:0] f; int w;
    @(negedge clk); latency = 8'd5;
    fork
      begin
        for (int k = 0; k < 40; k++) begin
          @(negedge clk); trig = 1'b1; tq[k] = ecnt;
        end
        @(negedge clk); trig = 1'b0;
      end
      begin
        for (int k = 0; k < 33; k++) begin
          get_frame(f, w, 1000);
          chk_frame(f, mkframe(k != 0, 0, tq[k] - 5, pat(tq[k] - 5)), "R3 R4 overflow frames");
        end
        get_frame(f, w, 400);
        chk(w == 400, "R3 dropped triggers send nothing", $sformatf("%0d", w), "400");
      end
    join
  endtask

  task automatic t_fast_reset();
    logic [265:0] f; int w, t;
    @(negedge clk); latency = 8'd3;
    pulse_trig(t);
    pulse_trig(t);
    while (!data_out) @(negedge clk);
    repeat (50) @(negedge clk);
    fast_rst = 1'b1;
    @(negedge clk); fast_rst = 1'b0;
    chk(data_out === 1'b0, "R8 frame aborted", $sformatf("%b", data_out), "0");
    get_frame(f, w, 400);
    chk(w == 400, "R8 buffer flushed", $sformatf("%0d", w), "400");
    pulse_trig(t);
    get_frame(f, w, 1000);
    chk_frame(f, mkframe(0, 0, t - 3, pat(t - 3)), "R8 flag cleared and pointer kept running");
    @(negedge clk);
    trig = 1'b1; fast_rst = 1'b1;
    @(negedge clk);
    trig = 1'b0; fast_rst = 1'b0;
    get_frame(f, w, 400);
    chk(w == 400, "R8 trigger with fast reset ignored", $sformatf("%0d", w), "400");
  endtask

  task automatic t_lat_zero();
    logic [265:0] f; int w, t;
    @(negedge clk); latency = 8'd0;
    pulse_trig(t);
    get_frame(f, w, 1000);
    chk_frame(f, mkframe(0, 1, t, pat(t - 256)), "R9 zero latency");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk(data_out === 1'b0, "R7 idle low", $sformatf("%b", data_out), "0");
    t_single(10);
    t_single(200);
    t_burst();
    t_overflow();
    t_fast_reset();
    t_lat_zero();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule